// File: doc/BRIEF.md
# Gated Integrate-and-Fire Neuron Core

This block models one non-leaky integrate-and-fire neuron stepped in discrete time. The neuron holds four state values: a membrane potential, a steady drive that never decays, a fast drive that shrinks exponentially, and a one-bit gate. The fast drive adds to the potential only while the gate is set. All values are signed fixed-point numbers. With the default bench scaling there are 12 fractional bits and one tick stands for 1 ms.

Synaptic events can arrive on any clock cycle. Each event carries a 2-bit kind and a signed weight, and it updates one state value straight away. A tick strobe advances time by one step. On a tick the core first applies any event presented in that same cycle. It then adds the drive, scaled by the membrane reciprocal, to the potential. It decays the fast drive by the fast reciprocal. Finally it compares the new potential with the threshold.

When the potential is strictly above the threshold, the core raises a one-cycle spike. It loads the potential with the reset level and clears the other three values. The two time constants are supplied as unsigned reciprocals with `RECIP_W` fractional bits, so each division is done as a multiply followed by a shift. The state values are brought out so they can be watched.

Top module: `gif_neuron_core`

## Requirements
- R1: After reset, spike is 0, the potential, steady drive and fast drive are all 0, and the gate is 0.
- R2: An event of kind 0 adds its weight to the potential, and the sum is visible on the cycle after the event. When the event arrives together with a tick, the sum is included in that tick's threshold comparison.
- R3: An event of kind 1 adds its weight to the steady drive. The steady drive is otherwise unchanged by ticks that do not spike.
- R4: An event of kind 2 adds its weight to the fast drive. On every tick that does not spike, the fast drive loses floor(fast × cfg_inv_tf / 2^RECIP_W).
- R5: An event of kind 3 sets the gate when its weight is positive and clears the gate when its weight is negative. A zero weight leaves the gate as it was.
- R6: On a tick, the potential gains floor((steady + (gate ? fast : 0)) × cfg_inv_tm / 2^RECIP_W). This uses the values after that cycle's event and before the fast drive decays.
- R7: A spike is raised only on a tick, and only if the potential after integration is strictly greater than cfg_thresh. A potential equal to the threshold does not spike.
- R8: A spike lasts one cycle, in the cycle after the tick. In that same cycle the potential equals cfg_vreset, and the steady drive, fast drive and gate are all 0.
- R9: Every addition to the potential, the steady drive or the fast drive saturates at the signed limits of DATA_W bits instead of wrapping around.
- R10: Events presented without a tick never change the potential through integration and never cause a spike.
- R11: Under the defaults (threshold 10.0, reset level 0, time constants 100 and 20 ticks), the following event sequence must make the core spike within ±2 ticks of a real-valued step model: potential +3.0 at tick 10, steady drive +6.0 at tick 25, then fast drive +16.0 and gate on at tick 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released through an internal synchronizer |
| tick | input | 1 | Advances the neuron by one time step |
| ev_valid | input | 1 | A synaptic event is present this cycle |
| ev_type | input | 2 | Event kind: 0 potential, 1 steady drive, 2 fast drive, 3 gate |
| ev_weight | input | DATA_W | Signed fixed-point event weight |
| cfg_thresh | input | DATA_W | Signed firing threshold |
| cfg_vreset | input | DATA_W | Signed potential loaded after a spike |
| cfg_inv_tm | input | RECIP_W | Unsigned reciprocal of the membrane time constant |
| cfg_inv_tf | input | RECIP_W | Unsigned reciprocal of the fast-drive time constant |
| spike | output | 1 | One-cycle spike pulse |
| v_state | output | DATA_W | Membrane potential |
| ge_state | output | DATA_W | Steady drive |
| gf_state | output | DATA_W | Fast drive |
| gate_state | output | 1 | Gate bit |

## Verification
The assertions check the following on every cycle:
- A spike only follows a tick.
- A tick with no spike leaves the potential at or below the threshold.
- A spike leaves the reset values behind.
- The steady drive holds between its own events and ticks.
- A positive fast drive never grows on a tick with no event.
- A non-negative potential event never makes the potential drop.

Only the bench scenarios can show the exact arithmetic:
- the integration and decay amounts, including how they are floored;
- the strict threshold at equality;
- the gate's response to weights of each sign;
- saturation at both limits;
- the firing time of the full trajectory compared with the real-valued reference.

// File: rtl/gif_pkg.sv
package gif_pkg;
  typedef enum logic [1:0] {
    EV_V    = 2'd0,
    EV_GE   = 2'd1,
    EV_GF   = 2'd2,
    EV_GATE = 2'd3
  } ev_kind_e;
endpackage

// File: rtl/gif_sat_add.sv
module gif_sat_add #(
  parameter int W = 28
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] sum;

  always_comb begin
    sum = {a[W-1], a} + {b[W-1], b};
    if (sum[W] != sum[W-1]) y = sum[W] ? MINV : MAXV;
    else                    y = sum[W-1:0];
  end
endmodule

// File: rtl/gif_event_apply.sv
module gif_event_apply
  import gif_pkg::*;
#(
  parameter int W = 28
) (
  input  logic               valid,
  input  logic [1:0]         kind,
  input  logic signed [W-1:0] weight,
  input  logic signed [W-1:0] v_i,
  input  logic signed [W-1:0] ge_i,
  input  logic signed [W-1:0] gf_i,
  input  logic               gate_i,
  output logic signed [W-1:0] v_o,
  output logic signed [W-1:0] ge_o,
  output logic signed [W-1:0] gf_o,
  output logic               gate_o
);
  logic signed [W-1:0] target;
  logic signed [W-1:0] summed;

  always_comb begin
    unique case (ev_kind_e'(kind))
      EV_V:    target = v_i;
      EV_GE:   target = ge_i;
      default: target = gf_i;
    endcase
  end

  gif_sat_add #(.W(W)) u_add (.a(target), .b(weight), .y(summed));

  always_comb begin
    v_o    = v_i;
    ge_o   = ge_i;
    gf_o   = gf_i;
    gate_o = gate_i;
    if (valid) begin
      unique case (ev_kind_e'(kind))
        EV_V:    v_o  = summed;
        EV_GE:   ge_o = summed;
        EV_GF:   gf_o = summed;
        EV_GATE: begin
          if (weight[W-1])        gate_o = 1'b0;
          else if (weight != '0)  gate_o = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/gif_integrate.sv
module gif_integrate #(
  parameter int W  = 28,
  parameter int RW = 20
) (
  input  logic signed [W-1:0] v_i,
  input  logic signed [W-1:0] ge_i,
  input  logic signed [W-1:0] gf_i,
  input  logic               gate_i,
  input  logic [RW-1:0]      inv_tm,
  input  logic [RW-1:0]      inv_tf,
  input  logic signed [W-1:0] thresh,
  output logic signed [W-1:0] v_o,
  output logic signed [W-1:0] gf_o,
  output logic               fire
);
  localparam int PW = W + RW + 2;
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0]    drive;
  logic signed [PW-1:0] drive_x, tm_x, prod_v, step_v;
  logic signed [PW-1:0] gf_x, tf_x, prod_f, step_f;
  logic signed [W-1:0]  dv;
  logic                 dv_fits;

  always_comb begin
    drive   = {ge_i[W-1], ge_i} + (gate_i ? {gf_i[W-1], gf_i} : '0);
    drive_x = {{(PW-W-1){drive[W]}}, drive};
    tm_x    = {{(PW-RW){1'b0}}, inv_tm};
    prod_v  = drive_x * tm_x;
    step_v  = prod_v >>> RW;
    dv_fits = (&step_v[PW-1:W-1]) | ~(|step_v[PW-1:W-1]);
    dv      = dv_fits ? step_v[W-1:0] : (step_v[PW-1] ? MINV : MAXV);

    gf_x    = {{(PW-W){gf_i[W-1]}}, gf_i};
    tf_x    = {{(PW-RW){1'b0}}, inv_tf};
    prod_f  = gf_x * tf_x;
    step_f  = prod_f >>> RW;
    gf_o    = gf_i - step_f[W-1:0];
  end

  gif_sat_add #(.W(W)) u_vadd (.a(v_i), .b(dv), .y(v_o));

  assign fire = (v_o > thresh);
endmodule

// File: rtl/gif_neuron_core.sv
module gif_neuron_core #(
  parameter int DATA_W  = 28,
  parameter int RECIP_W = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      ev_valid,
  input  logic [1:0]                ev_type,
  input  logic signed [DATA_W-1:0]  ev_weight,
  input  logic signed [DATA_W-1:0]  cfg_thresh,
  input  logic signed [DATA_W-1:0]  cfg_vreset,
  input  logic [RECIP_W-1:0]        cfg_inv_tm,
  input  logic [RECIP_W-1:0]        cfg_inv_tf,
  output logic                      spike,
  output logic signed [DATA_W-1:0]  v_state,
  output logic signed [DATA_W-1:0]  ge_state,
  output logic signed [DATA_W-1:0]  gf_state,
  output logic                      gate_state
);
  logic rs_meta, rs_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_sync <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_sync <= rs_meta;
    end
  end

  logic signed [DATA_W-1:0] v_q, ge_q, gf_q;
  logic                     gate_q, spike_q;
  logic signed [DATA_W-1:0] a_v, a_ge, a_gf;
  logic                     a_gate;
  logic signed [DATA_W-1:0] i_v, i_gf;
  logic                     i_fire;
  logic signed [DATA_W-1:0] v_d, ge_d, gf_d;
  logic                     gate_d, spike_d, state_en;

  gif_event_apply #(.W(DATA_W)) u_evt (
    .valid (ev_valid), .kind (ev_type), .weight (ev_weight),
    .v_i (v_q), .ge_i (ge_q), .gf_i (gf_q), .gate_i (gate_q),
    .v_o (a_v), .ge_o (a_ge), .gf_o (a_gf), .gate_o (a_gate)
  );

  gif_integrate #(.W(DATA_W), .RW(RECIP_W)) u_int (
    .v_i (a_v), .ge_i (a_ge), .gf_i (a_gf), .gate_i (a_gate),
    .inv_tm (cfg_inv_tm), .inv_tf (cfg_inv_tf), .thresh (cfg_thresh),
    .v_o (i_v), .gf_o (i_gf), .fire (i_fire)
  );

  always_comb begin
    state_en = tick | ev_valid;
    spike_d  = 1'b0;
    v_d      = a_v;
    ge_d     = a_ge;
    gf_d     = a_gf;
    gate_d   = a_gate;
    if (tick) begin
      if (i_fire) begin
        spike_d = 1'b1;
        v_d     = cfg_vreset;
        ge_d    = '0;
        gf_d    = '0;
        gate_d  = 1'b0;
      end else begin
        v_d  = i_v;
        gf_d = i_gf;
      end
    end
  end

  always_ff @(posedge clk or negedge rs_sync) begin
    if (!rs_sync) begin
      v_q     <= '0;
      ge_q    <= '0;
      gf_q    <= '0;
      gate_q  <= 1'b0;
      spike_q <= 1'b0;
    end else begin
      spike_q <= spike_d;
      if (state_en) begin
        v_q    <= v_d;
        ge_q   <= ge_d;
        gf_q   <= gf_d;
        gate_q <= gate_d;
      end
    end
  end

  assign spike      = spike_q;
  assign v_state    = v_q;
  assign ge_state   = ge_q;
  assign gf_state   = gf_q;
  assign gate_state = gate_q;
endmodule

// File: rtl/gif_neuron_chk.sv
module gif_neuron_chk
  import gif_pkg::*;
#(
  parameter int DATA_W  = 28,
  parameter int RECIP_W = 20
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick,
  input logic                     ev_valid,
  input logic [1:0]               ev_type,
  input logic signed [DATA_W-1:0] ev_weight,
  input logic signed [DATA_W-1:0] cfg_thresh,
  input logic signed [DATA_W-1:0] cfg_vreset,
  input logic                     spike,
  input logic signed [DATA_W-1:0] v_state,
  input logic signed [DATA_W-1:0] ge_state,
  input logic signed [DATA_W-1:0] gf_state,
  input logic                     gate_state
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_spike_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    spike |-> $past(tick));

  assert_below_thresh_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    tick |=> (spike || v_state <= $past(cfg_thresh)));

  assert_spike_clears_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    spike |-> (ge_state == '0 && gf_state == '0 && !gate_state && v_state == $past(cfg_vreset)));

  assert_ge_holds_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!tick && !(ev_valid && ev_type == EV_GE)) |=> $stable(ge_state));

  assert_gf_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (tick && !ev_valid && gf_state >= 0) |=> (gf_state >= 0 && gf_state <= $past(gf_state)));

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!tick && ev_valid && ev_type == EV_V && ev_weight >= 0) |=> (v_state >= $past(v_state)));
endmodule

bind gif_neuron_core gif_neuron_chk #(.DATA_W(DATA_W), .RECIP_W(RECIP_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .tick (tick), .ev_valid (ev_valid),
  .ev_type (ev_type), .ev_weight (ev_weight), .cfg_thresh (cfg_thresh),
  .cfg_vreset (cfg_vreset), .spike (spike), .v_state (v_state),
  .ge_state (ge_state), .gf_state (gf_state), .gate_state (gate_state)
);

// File: tb/tb_gif_neuron_core.sv
module tb_gif_neuron_core;
  localparam int W    = 28;
  localparam int RW   = 20;
  localparam int FRAC = 12;
  localparam longint ONE   = 64'sd1 <<< FRAC;
  localparam longint MAXV  = (64'sd1 <<< (W-1)) - 1;
  localparam longint MINV  = -(64'sd1 <<< (W-1));
  localparam longint INVTM = 10486;
  localparam longint INVTF = 52429;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, ev_valid;
  logic [1:0] ev_type;
  logic signed [W-1:0] ev_weight, cfg_thresh, cfg_vreset;
  logic [RW-1:0] cfg_inv_tm, cfg_inv_tf;
  logic spike, gate_state;
  logic signed [W-1:0] v_state, ge_state, gf_state;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gif_neuron_core #(.DATA_W(W), .RECIP_W(RW)) dut (
    .clk (clk), .rst_n (rst_n), .tick (tick), .ev_valid (ev_valid),
    .ev_type (ev_type), .ev_weight (ev_weight), .cfg_thresh (cfg_thresh),
    .cfg_vreset (cfg_vreset), .cfg_inv_tm (cfg_inv_tm), .cfg_inv_tf (cfg_inv_tf),
    .spike (spike), .v_state (v_state), .ge_state (ge_state),
    .gf_state (gf_state), .gate_state (gate_state)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint incr(input longint ge, input longint gf, input bit g);
    return ((ge + (g ? gf : 0)) * INVTM) >>> RW;
  endfunction

  function automatic longint decay(input longint gf);
    return (gf * INVTF) >>> RW;
  endfunction

  task automatic step(input bit t, input bit v, input logic [1:0] k, input longint w);
    @(negedge clk);
    tick = t; ev_valid = v; ev_type = k; ev_weight = w[W-1:0];
    @(negedge clk);
    tick = 1'b0; ev_valid = 1'b0; ev_type = 2'd0; ev_weight = '0;
  endtask

  task automatic do_reset(input longint thr, input longint vrs);
    tick = 0; ev_valid = 0; ev_type = 0; ev_weight = '0;
    cfg_thresh = thr[W-1:0]; cfg_vreset = vrs[W-1:0];
    cfg_inv_tm = INVTM[RW-1:0]; cfg_inv_tf = INVTF[RW-1:0];
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(10*ONE, 0);
    chk("R1 spike", spike, 0);
    chk("R1 v", v_state, 0);
    chk("R1 ge", ge_state, 0);
    chk("R1 gf", gf_state, 0);
    chk("R1 gate", gate_state, 0);
  endtask

  task automatic t_v_event;
    do_reset(10*ONE, 0);
    step(0, 1, 2'd0, 3*ONE);
    chk("R2 v add", v_state, 3*ONE);
    step(0, 1, 2'd0, -ONE);
    chk("R2 v sub", v_state, 2*ONE);
    do_reset(ONE, ONE/2);
    step(1, 1, 2'd0, ONE + 5);
    chk("R2 same-tick spike", spike, 1);
    chk("R2 v reset", v_state, ONE/2);
  endtask

  task automatic t_ge_hold;
    longint ev = 0;
    do_reset(10*ONE, 0);
    step(0, 1, 2'd1, 6*ONE);
    for (int i = 0; i < 3; i++) begin
      step(1, 0, 2'd0, 0);
      ev += incr(6*ONE, 0, 0);
    end
    chk("R3 ge held", ge_state, 6*ONE);
    chk("R6 v from ge", v_state, ev);
  endtask

  task automatic t_gf_decay;
    longint g = 16*ONE;
    do_reset(10*ONE, 0);
    step(0, 1, 2'd2, g);
    chk("R4 gf add", gf_state, g);
    step(1, 0, 2'd0, 0);
    g = g - decay(g);
    chk("R4 gf decay 1", gf_state, g);
    step(1, 0, 2'd0, 0);
    g = g - decay(g);
    chk("R4 gf decay 2", gf_state, g);
    chk("R6 gate off no v", v_state, 0);
  endtask

  task automatic t_gate;
    longint g = 2*ONE;
    longint v;
    do_reset(10*ONE, 0);
    step(0, 1, 2'd3, ONE);
    chk("R5 gate set", gate_state, 1);
    step(0, 1, 2'd3, 0);
    chk("R5 gate zero weight", gate_state, 1);
    step(0, 1, 2'd3, 3*ONE);
    chk("R5 gate saturates", gate_state, 1);
    step(0, 1, 2'd2, g);
    step(1, 1, 2'd1, ONE);
    v = incr(ONE, g, 1);
    chk("R6 gated integrate", v_state, v);
    chk("R4 gf after tick", gf_state, g - decay(g));
    step(0, 1, 2'd3, -ONE);
    chk("R5 gate clear", gate_state, 0);
    step(0, 1, 2'd3, -ONE);
    chk("R5 gate floor", gate_state, 0);
  endtask

  task automatic t_threshold;
    longint d;
    do_reset(ONE, ONE/2);
    step(0, 1, 2'd0, ONE);
    step(1, 0, 2'd0, 0);
    chk("R7 equal no spike", spike, 0);
    chk("R7 v equal", v_state, ONE);
    step(0, 1, 2'd1, ONE);
    step(0, 1, 2'd2, 2*ONE);
    step(0, 1, 2'd3, ONE);
    d = incr(ONE, 2*ONE, 1);
    @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
    chk("R7 above spike", spike, (ONE + d > ONE) ? 1 : 0);
    chk("R8 v reload", v_state, ONE/2);
    chk("R8 ge clear", ge_state, 0);
    chk("R8 gf clear", gf_state, 0);
    chk("R8 gate clear", gate_state, 0);
    @(negedge clk);
    chk("R8 one cycle", spike, 0);
  endtask

  task automatic t_saturate;
    do_reset(MAXV, 0);
    step(0, 1, 2'd0, MAXV);
    step(0, 1, 2'd0, MAXV);
    chk("R9 v high", v_state, MAXV);
    step(0, 1, 2'd1, MINV);
    step(0, 1, 2'd1, MINV);
    chk("R9 ge low", ge_state, MINV);
    step(0, 1, 2'd2, MAXV);
    step(0, 1, 2'd2, 5);
    chk("R9 gf high", gf_state, MAXV);
  endtask

  task automatic t_no_tick;
    do_reset(ONE, 0);
    step(0, 1, 2'd1, 8*ONE);
    repeat (4) begin
      @(negedge clk);
      chk("R10 no spike idle", spike, 0);
    end
    chk("R10 v untouched", v_state, 0);
    step(0, 1, 2'd0, 2*ONE);
    chk("R10 over thr no spike", spike, 0);
    chk("R10 v held", v_state, 2*ONE);
  endtask

  task automatic t_trajectory;
    real rv = 0.0, rge = 0.0, rgf = 0.0, rg = 0.0;
    int ref_t = -1;
    int dut_t = -1;
    int diff;
    for (int t = 1; t <= 150 && ref_t < 0; t++) begin
      if (t == 10) rv += 3.0;
      if (t == 25) rge += 6.0;
      if (t == 40) begin rgf += 16.0; rg = 1.0; end
      rv += (rge + rg * rgf) / 100.0;
      rgf -= rgf / 20.0;
      if (rv > 10.0) ref_t = t;
    end
    do_reset(10*ONE, 0);
    for (int t = 1; t <= 150 && dut_t < 0; t++) begin
      if (t == 10)      step(0, 1, 2'd0, 3*ONE);
      else if (t == 25) step(0, 1, 2'd1, 6*ONE);
      else if (t == 40) step(0, 1, 2'd2, 16*ONE);
      else              step(0, 0, 2'd0, 0);
      if (t == 40) step(1, 1, 2'd3, ONE);
      else         step(1, 0, 2'd0, 0);
      if (spike) dut_t = t;
    end
    diff = dut_t - ref_t;
    if (diff < 0) diff = -diff;
    chk("R11 spike within 2 ticks", (dut_t > 0 && diff <= 2) ? 1 : 0, 1);
    if (dut_t < 0 || diff > 2) $display("  R11 detail dut=%0d ref=%0d", dut_t, ref_t);
    chk("R8 v after trajectory", v_state, 0);
    chk("R8 ge after trajectory", ge_state, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    t_reset;
    t_v_event;
    t_ge_hold;
    t_gf_decay;
    t_gate;
    t_threshold;
    t_saturate;
    t_no_tick;
    t_trajectory;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule